// File: doc/BRIEF.md
# HDMI Line Period Sequencer

This block runs at the pixel clock and classifies each position of a scanline into one of the HDMI link periods: active video, plain control, data-island preamble, leading guard band, island packet characters, trailing guard band, video preamble and video guard band. For each position it produces the period code, the four control bits carried during control periods, a symbol-kind select for each of the three TMDS lanes, the fixed 10-bit guard-band characters, and the character index inside the island packet. The downstream encoders (8b/10b video, TERC4, control symbols) and the serialiser use these outputs to pick what they send. Those encoders are outside this block.

The horizontal counter, the two sync levels and a "packet available" flag come in from the timing generator and the packet source. One 32-character packet can be placed per line, right after active video and behind a control run long enough for the receiver to lock onto the preamble. If no packet is offered, or the block is built in DVI mode, the island slots stay plain control. Every output is registered, so the outputs lag the counter by one clock.

Top module: `line_period_sequencer`

## Requirements
- R1: A synchronous reset makes the outputs on the next clock show the control period (code 0), control bits 0000, all lane selects 0, all guard codes 0 and packet index 0.
- R2: For counter values 0..719 the period code is 1 (video), the control bits are 0000 and every lane select is 1 (video symbols). Outputs appear one clock after the counter value.
- R3: With an island on the line, counter values 724..731 give period code 2 (island preamble), control bits 4'b0101 and lane selects 0 (control symbols).
- R4: With an island on the line, counter values 732..733 (period 3) and 766..767 (period 5) are guard bands. Every lane select is 3 (guard). Lanes 1 and 2 carry 10'b0100110011. Lane 0 carries the TERC4 character of {1,1,vsync,hsync}. That character is 10'b1010001110 for 0xC, 10'b1001110001 for 0xD, 10'b0101100011 for 0xE and 10'b1011000011 for 0xF. The control bits are 0000.
- R5: With an island on the line, counter values 734..765 give period code 4. Every lane select is 2 (TERC4), and the packet index runs from 0 to 31 as the counter rises.
- R6: Any position not covered by another period is the control period (code 0). There, the control bits are 0000, the selects are 0, the guard codes are 0 and the index is 0.
- R7: Counter values 848..855 give period code 6 (video preamble) with control bits 4'b0001 and selects 0.
- R8: Counter values 856..857 give period code 7 (video guard band). Every select is 3. Lanes 0 and 2 carry 10'b1011001100 and lane 1 carries 10'b0100110011.
- R9: The packet-available flag is sampled only when the counter equals 724. Its value at any other position has no effect on that line.
- R10: If the flag is low at counter 724, or no line start (counter 0) has been seen since reset, the island slots 724..767 stay in the control period.
- R11: When built in DVI mode, the block never produces periods 2 to 5.
- R12: At least 12 consecutive control-coded clocks (periods 0 or 2) come right before every leading guard band.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hcount_i | input | CNT_W (10) | Horizontal pixel counter |
| hsync_i | input | 1 | Horizontal sync level |
| vsync_i | input | 1 | Vertical sync level |
| pkt_avail_i | input | 1 | A packet is ready for this line |
| period_o | output | 3 | Period code (0 control, 1 video, 2 island preamble, 3 leading guard, 4 island data, 5 trailing guard, 6 video preamble, 7 video guard) |
| ctl_o | output | 4 | Control bits for control-coded periods |
| sym_sel_o | output | 6 | Lane symbol kind, lane 0 in bits 1:0 (0 control, 1 video, 2 TERC4, 3 guard) |
| guard0_o | output | 10 | Lane 0 guard character, 0 outside guard bands |
| guard1_o | output | 10 | Lane 1 guard character, 0 outside guard bands |
| guard2_o | output | 10 | Lane 2 guard character, 0 outside guard bands |
| pkt_idx_o | output | $clog2(PKT_LEN) (5) | Island character index |

## Verification
The bench builds two copies of the block with the 720x480 defaults (858-clock line, 4-clock gap, 8-clock preambles, 2-clock guards, 32-character packet). One copy has islands enabled and the other is in DVI mode. Both see the same stimulus, so every line compares an island line against a plain control line position by position. The bench sweeps all four sync combinations to reach all four lane-0 guard characters. It toggles the packet flag away from the sampling position, and it resets in the middle of an island and then restarts the counter mid-line, which reaches the rule that no island is allowed before a line start.

// File: rtl/line_seq_pkg.sv
package line_seq_pkg;

    typedef enum logic [2:0] {
        PER_CTRL      = 3'd0,
        PER_VIDEO     = 3'd1,
        PER_DI_PRE    = 3'd2,
        PER_DI_LEAD   = 3'd3,
        PER_DI_DATA   = 3'd4,
        PER_DI_TRAIL  = 3'd5,
        PER_VID_PRE   = 3'd6,
        PER_VID_GUARD = 3'd7
    } period_e;

    typedef enum logic [1:0] {
        SYM_CTRL  = 2'd0,
        SYM_VIDEO = 2'd1,
        SYM_TERC4 = 2'd2,
        SYM_GUARD = 2'd3
    } sym_e;

    localparam logic [9:0] GUARD_LOW_CODE  = 10'b0100110011;
    localparam logic [9:0] GUARD_HIGH_CODE = 10'b1011001100;
    localparam logic [3:0] CTL_ISLAND_PRE  = 4'b0101;
    localparam logic [3:0] CTL_VIDEO_PRE   = 4'b0001;

    typedef struct packed {
        period_e    period;
        logic [3:0] ctl;
        sym_e       sel2;
        sym_e       sel1;
        sym_e       sel0;
        logic [9:0] g2;
        logic [9:0] g1;
        logic [9:0] g0;
    } lane_word_t;

    // TERC4 character for the island guard on lane 0: nibble {1,1,vsync,hsync}
    function automatic logic [9:0] sync_guard_char(input logic hs, input logic vs);
        logic [9:0] c;
        case ({vs, hs})
            2'b00:   c = 10'b1010001110;
            2'b01:   c = 10'b1001110001;
            2'b10:   c = 10'b0101100011;
            default: c = 10'b1011000011;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/island_gate.sv
module island_gate #(
    parameter int CNT_W    = 10,
    parameter int PRE_POS  = 724,
    parameter bit DVI_MODE = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] hcount,
    input  logic             pkt_avail,
    output logic             island
);
    localparam logic [CNT_W-1:0] PRE_S = CNT_W'(PRE_POS);

    logic line_seen_q;
    logic island_q;
    logic grant;

    generate
        if (DVI_MODE) begin : g_dvi
            assign grant = 1'b0;
        end else begin : g_hdmi
            assign grant = pkt_avail & line_seen_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            line_seen_q <= 1'b0;
            island_q    <= 1'b0;
        end else begin
            if (hcount == '0)
                line_seen_q <= 1'b1;
            if (hcount == PRE_S)
                island_q <= grant;
        end
    end

    assign island = (hcount == PRE_S) ? grant : island_q;
endmodule

// File: rtl/line_period_decoder.sv
module line_period_decoder
    import line_seq_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int H_ACTIVE = 720,
    parameter int H_TOTAL  = 858,
    parameter int DI_GAP   = 4,
    parameter int PRE_LEN  = 8,
    parameter int GB_LEN   = 2,
    parameter int PKT_LEN  = 32
) (
    input  logic [CNT_W-1:0] hcount,
    input  logic             island,
    output period_e          period
);
    localparam logic [CNT_W-1:0] ACT_E   = CNT_W'(H_ACTIVE);
    localparam logic [CNT_W-1:0] PRE_S   = CNT_W'(H_ACTIVE + DI_GAP);
    localparam logic [CNT_W-1:0] LEAD_S  = CNT_W'(H_ACTIVE + DI_GAP + PRE_LEN);
    localparam logic [CNT_W-1:0] DATA_S  = CNT_W'(H_ACTIVE + DI_GAP + PRE_LEN + GB_LEN);
    localparam logic [CNT_W-1:0] TRAIL_S = CNT_W'(H_ACTIVE + DI_GAP + PRE_LEN + GB_LEN + PKT_LEN);
    localparam logic [CNT_W-1:0] TRAIL_E = CNT_W'(H_ACTIVE + DI_GAP + PRE_LEN + 2*GB_LEN + PKT_LEN);
    localparam logic [CNT_W-1:0] VPRE_S  = CNT_W'(H_TOTAL - GB_LEN - PRE_LEN);
    localparam logic [CNT_W-1:0] VGB_S   = CNT_W'(H_TOTAL - GB_LEN);
    localparam logic [CNT_W-1:0] TOT     = CNT_W'(H_TOTAL);

    always_comb begin
        if (hcount < ACT_E)
            period = PER_VIDEO;
        else if (island && hcount >= PRE_S && hcount < LEAD_S)
            period = PER_DI_PRE;
        else if (island && hcount >= LEAD_S && hcount < DATA_S)
            period = PER_DI_LEAD;
        else if (island && hcount >= DATA_S && hcount < TRAIL_S)
            period = PER_DI_DATA;
        else if (island && hcount >= TRAIL_S && hcount < TRAIL_E)
            period = PER_DI_TRAIL;
        else if (hcount >= VPRE_S && hcount < VGB_S)
            period = PER_VID_PRE;
        else if (hcount >= VGB_S && hcount < TOT)
            period = PER_VID_GUARD;
        else
            period = PER_CTRL;
    end
endmodule

// File: rtl/lane_symbol_mapper.sv
module lane_symbol_mapper
    import line_seq_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int DATA_POS = 734,
    parameter int IDX_W    = 5
) (
    input  period_e          period,
    input  logic [CNT_W-1:0] hcount,
    input  logic             hsync,
    input  logic             vsync,
    output lane_word_t       word,
    output logic [IDX_W-1:0] idx
);
    localparam logic [CNT_W-1:0] DATA_S = CNT_W'(DATA_POS);

    logic [CNT_W-1:0] offset;
    assign offset = hcount - DATA_S;

    always_comb begin
        word        = '0;
        word.period = period;
        word.sel0   = SYM_CTRL;
        word.sel1   = SYM_CTRL;
        word.sel2   = SYM_CTRL;
        idx         = '0;
        case (period)
            PER_VIDEO: begin
                word.sel0 = SYM_VIDEO;
                word.sel1 = SYM_VIDEO;
                word.sel2 = SYM_VIDEO;
            end
            PER_DI_PRE:  word.ctl = CTL_ISLAND_PRE;
            PER_VID_PRE: word.ctl = CTL_VIDEO_PRE;
            PER_DI_LEAD, PER_DI_TRAIL: begin
                word.sel0 = SYM_GUARD;
                word.sel1 = SYM_GUARD;
                word.sel2 = SYM_GUARD;
                word.g0   = sync_guard_char(hsync, vsync);
                word.g1   = GUARD_LOW_CODE;
                word.g2   = GUARD_LOW_CODE;
            end
            PER_DI_DATA: begin
                word.sel0 = SYM_TERC4;
                word.sel1 = SYM_TERC4;
                word.sel2 = SYM_TERC4;
                idx       = offset[IDX_W-1:0];
            end
            PER_VID_GUARD: begin
                word.sel0 = SYM_GUARD;
                word.sel1 = SYM_GUARD;
                word.sel2 = SYM_GUARD;
                word.g0   = GUARD_HIGH_CODE;
                word.g1   = GUARD_LOW_CODE;
                word.g2   = GUARD_HIGH_CODE;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/line_period_sequencer.sv
module line_period_sequencer
    import line_seq_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int H_ACTIVE = 720,
    parameter int H_TOTAL  = 858,
    parameter int DI_GAP   = 4,
    parameter int PRE_LEN  = 8,
    parameter int GB_LEN   = 2,
    parameter int PKT_LEN  = 32,
    parameter bit DVI_MODE = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [CNT_W-1:0]           hcount_i,
    input  logic                       hsync_i,
    input  logic                       vsync_i,
    input  logic                       pkt_avail_i,
    output logic [2:0]                 period_o,
    output logic [3:0]                 ctl_o,
    output logic [5:0]                 sym_sel_o,
    output logic [9:0]                 guard0_o,
    output logic [9:0]                 guard1_o,
    output logic [9:0]                 guard2_o,
    output logic [$clog2(PKT_LEN)-1:0] pkt_idx_o
);
    localparam int IDX_W    = $clog2(PKT_LEN);
    localparam int PRE_POS  = H_ACTIVE + DI_GAP;
    localparam int DATA_POS = H_ACTIVE + DI_GAP + PRE_LEN + GB_LEN;
    localparam int MIN_CTRL = 12;

    logic             island;
    period_e          period_d;
    lane_word_t       word_d, word_q;
    logic [IDX_W-1:0] idx_d, idx_q;

    island_gate #(
        .CNT_W(CNT_W), .PRE_POS(PRE_POS), .DVI_MODE(DVI_MODE)
    ) gate_i (
        .clk(clk), .rst(rst), .hcount(hcount_i),
        .pkt_avail(pkt_avail_i), .island(island)
    );

    line_period_decoder #(
        .CNT_W(CNT_W), .H_ACTIVE(H_ACTIVE), .H_TOTAL(H_TOTAL), .DI_GAP(DI_GAP),
        .PRE_LEN(PRE_LEN), .GB_LEN(GB_LEN), .PKT_LEN(PKT_LEN)
    ) dec_i (
        .hcount(hcount_i), .island(island), .period(period_d)
    );

    lane_symbol_mapper #(
        .CNT_W(CNT_W), .DATA_POS(DATA_POS), .IDX_W(IDX_W)
    ) map_i (
        .period(period_d), .hcount(hcount_i), .hsync(hsync_i), .vsync(vsync_i),
        .word(word_d), .idx(idx_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            idx_q  <= '0;
        end else begin
            word_q <= word_d;
            idx_q  <= idx_d;
        end
    end

    assign period_o  = word_q.period;
    assign ctl_o     = word_q.ctl;
    assign sym_sel_o = {word_q.sel2, word_q.sel1, word_q.sel0};
    assign guard0_o  = word_q.g0;
    assign guard1_o  = word_q.g1;
    assign guard2_o  = word_q.g2;
    assign pkt_idx_o = idx_q;

    // run of control-coded output clocks, saturating
    logic [4:0] ctrl_run_q;
    always_ff @(posedge clk) begin
        if (rst)
            ctrl_run_q <= '0;
        else if (word_q.period == PER_CTRL || word_q.period == PER_DI_PRE)
            ctrl_run_q <= (ctrl_run_q == 5'd31) ? ctrl_run_q : ctrl_run_q + 5'd1;
        else
            ctrl_run_q <= '0;
    end

    assert_min_ctrl_R12: assert property (@(posedge clk) disable iff (rst)
        (word_q.period == PER_DI_LEAD && $past(word_q.period) == PER_DI_PRE)
            |-> (ctrl_run_q >= 5'(MIN_CTRL)));

    assert_pre_ctl_R3: assert property (@(posedge clk) disable iff (rst)
        (period_o == 3'd2) |-> (ctl_o == 4'b0101));

    assert_guard_char_R4: assert property (@(posedge clk) disable iff (rst)
        (period_o == 3'd3 || period_o == 3'd5) |->
            (guard0_o == 10'b1010001110 || guard0_o == 10'b1001110001 ||
             guard0_o == 10'b0101100011 || guard0_o == 10'b1011000011));

    assert_island_entry_R5: assert property (@(posedge clk) disable iff (rst)
        (period_o == 3'd4 && $past(period_o) != 3'd4) |-> ($past(period_o) == 3'd3));

    assert_index_step_R5: assert property (@(posedge clk) disable iff (rst)
        (period_o == 3'd4 && $past(period_o) == 3'd4) |-> (pkt_idx_o == $past(pkt_idx_o) + 1'b1));

    assert_no_island_dvi_R11: assert property (@(posedge clk) disable iff (rst)
        DVI_MODE |-> (period_o < 3'd2 || period_o > 3'd5));
endmodule

// File: tb/line_period_sequencer_tb.sv
module line_period_sequencer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int H_TOTAL    = 858;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] hcount = '0;
    logic       hsync = 1'b0, vsync = 1'b0, pkt_avail = 1'b0;

    logic [2:0] per_a, per_b;
    logic [3:0] ctl_a, ctl_b;
    logic [5:0] sel_a, sel_b;
    logic [9:0] g0_a, g1_a, g2_a, g0_b, g1_b, g2_b;
    logic [4:0] idx_a, idx_b;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_period_sequencer dut_i (
        .clk(clk), .rst(rst), .hcount_i(hcount), .hsync_i(hsync), .vsync_i(vsync),
        .pkt_avail_i(pkt_avail), .period_o(per_a), .ctl_o(ctl_a), .sym_sel_o(sel_a),
        .guard0_o(g0_a), .guard1_o(g1_a), .guard2_o(g2_a), .pkt_idx_o(idx_a));

    line_period_sequencer #(.DVI_MODE(1'b1)) dut_dvi_i (
        .clk(clk), .rst(rst), .hcount_i(hcount), .hsync_i(hsync), .vsync_i(vsync),
        .pkt_avail_i(pkt_avail), .period_o(per_b), .ctl_o(ctl_b), .sym_sel_o(sel_b),
        .guard0_o(g0_b), .guard1_o(g1_b), .guard2_o(g2_b), .pkt_idx_o(idx_b));

    // previous drive, compared one clock later
    bit   p_valid = 0;
    int   p_h;
    bit   p_isl, p_hs, p_vs;
    bit   seen = 0;
    bit   isl_line = 0;
    int   run_a = 0;
    logic [2:0] last_per_a = 3'd0;

    function automatic logic [9:0] sync_char(input bit hs, input bit vs);
        case ({vs, hs})
            2'b00:   return 10'b1010001110;
            2'b01:   return 10'b1001110001;
            2'b10:   return 10'b0101100011;
            default: return 10'b1011000011;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] per);
        case (per)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3, 3'd5: return "R4";
            3'd4: return "R5";
            3'd6: return "R7";
            3'd7: return "R8";
            default: return "R6";
        endcase
    endfunction

    task automatic compare_one(input string tag, input string inst, input int h, input bit isl,
                               input bit hs, input bit vs,
                               input logic [2:0] per, input logic [3:0] ctl, input logic [5:0] sel,
                               input logic [9:0] g0, input logic [9:0] g1, input logic [9:0] g2,
                               input logic [4:0] idx);
        logic [2:0] e_per; logic [3:0] e_ctl; logic [5:0] e_sel;
        logic [9:0] e_g0, e_g1, e_g2; logic [4:0] e_idx;
        e_per = 3'd0; e_ctl = 4'd0; e_sel = 6'd0; e_g0 = '0; e_g1 = '0; e_g2 = '0; e_idx = '0;
        if (h < 720) begin e_per = 3'd1; e_sel = 6'b010101; end
        else if (isl && h >= 724 && h < 732) begin e_per = 3'd2; e_ctl = 4'b0101; end
        else if (isl && ((h >= 732 && h < 734) || (h >= 766 && h < 768))) begin
            e_per = (h < 734) ? 3'd3 : 3'd5; e_sel = 6'b111111;
            e_g0 = sync_char(hs, vs); e_g1 = 10'b0100110011; e_g2 = 10'b0100110011;
        end
        else if (isl && h >= 734 && h < 766) begin
            e_per = 3'd4; e_sel = 6'b101010; e_idx = 5'(h - 734);
        end
        else if (h >= 848 && h < 856) begin e_per = 3'd6; e_ctl = 4'b0001; end
        else if (h >= 856 && h < 858) begin
            e_per = 3'd7; e_sel = 6'b111111;
            e_g0 = 10'b1011001100; e_g1 = 10'b0100110011; e_g2 = 10'b1011001100;
        end
        checks++;
        if (per !== e_per || ctl !== e_ctl || sel !== e_sel || g0 !== e_g0 ||
            g1 !== e_g1 || g2 !== e_g2 || idx !== e_idx) begin
            failures++;
            $display("FAIL %s %s %s h=%0d actual per=%0d ctl=%b sel=%b g=%b/%b/%b idx=%0d expected per=%0d ctl=%b sel=%b g=%b/%b/%b idx=%0d",
                     req_of(e_per), tag, inst, h, per, ctl, sel, g0, g1, g2, idx,
                     e_per, e_ctl, e_sel, e_g0, e_g1, e_g2, e_idx);
        end
    endtask

    task automatic check_prev(input string tag);
        if (!p_valid) return;
        compare_one(tag, "hdmi", p_h, p_isl, p_hs, p_vs, per_a, ctl_a, sel_a, g0_a, g1_a, g2_a, idx_a);
        compare_one(tag, "dvi", p_h, 1'b0, p_hs, p_vs, per_b, ctl_b, sel_b, g0_b, g1_b, g2_b, idx_b);
        // R12: control run ahead of each leading guard
        if (per_a == 3'd3 && last_per_a != 3'd3) begin
            checks++;
            if (run_a < 12) begin
                failures++;
                $display("FAIL R12 control run actual=%0d expected>=12", run_a);
            end
        end
        run_a = (per_a == 3'd0 || per_a == 3'd2) ? run_a + 1 : 0;
        last_per_a = per_a;
    endtask

    // drives counter values first..last-1; flag is pa_at at 724 and pa_other elsewhere
    task automatic run_line(input int first, input int last, input bit pa_at, input bit pa_other,
                            input bit hs, input bit vs, input string tag);
        for (int h = first; h < last; h++) begin
            @(negedge clk);
            check_prev(tag);
            hcount    = 10'(h);
            hsync     = hs;
            vsync     = vs;
            pkt_avail = (h == 724) ? pa_at : pa_other;
            if (h == 724) isl_line = pa_at && seen;
            if (h == 0) seen = 1;
            p_valid = 1; p_h = h; p_hs = hs; p_vs = vs;
            p_isl = isl_line;
        end
    endtask

    task automatic flush(input string tag);
        @(negedge clk);
        check_prev(tag);
        p_valid = 0;
    endtask

    task automatic test_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        checks++;
        if (per_a !== 3'd0 || ctl_a !== 4'd0 || sel_a !== 6'd0 || g0_a !== 10'd0 ||
            g1_a !== 10'd0 || g2_a !== 10'd0 || idx_a !== 5'd0) begin
            failures++;
            $display("FAIL R1 %s actual per=%0d ctl=%b sel=%b g0=%b idx=%0d expected all zero",
                     tag, per_a, ctl_a, sel_a, g0_a, idx_a);
        end
        rst = 1'b0;
        p_valid = 0; seen = 0; isl_line = 0; run_a = 0; last_per_a = 3'd0;
    endtask

    task automatic test_island_syncs();
        run_line(0, H_TOTAL, 1, 1, 0, 0, "island hs0 vs0");
        run_line(0, H_TOTAL, 1, 1, 1, 0, "island hs1 vs0");
        run_line(0, H_TOTAL, 1, 1, 0, 1, "island hs0 vs1");
        run_line(0, H_TOTAL, 1, 1, 1, 1, "island hs1 vs1");
        flush("island");
    endtask

    task automatic test_no_packet_R10();
        run_line(0, H_TOTAL, 0, 0, 0, 0, "R10 no packet");
        flush("R10");
    endtask

    task automatic test_flag_timing_R9();
        run_line(0, H_TOTAL, 1, 0, 0, 1, "R9 flag only at 724");
        run_line(0, H_TOTAL, 0, 1, 0, 1, "R9 flag away from 724");
        flush("R9");
    endtask

    task automatic test_midline_reset();
        run_line(0, 740, 1, 1, 1, 0, "island before reset");
        test_reset("mid-island");
        run_line(700, H_TOTAL, 1, 1, 1, 0, "R10 no line start yet");
        run_line(0, H_TOTAL, 1, 1, 1, 0, "island after restart");
        flush("restart");
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                failures++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        test_reset("power-up");
        test_island_syncs();
        test_no_packet_R10();
        test_flag_timing_R9();
        test_midline_reset();
        // R11 is covered by the dvi instance compared on every line above
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule